// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block produces the master-side clock and data waveforms for an I2C controller. One 8-bit configuration byte sets all timing. Its top two bits select a power-of-two multiplier and its low six bits select a row of an internal timing table. Each row gives an SCL divider and three hold values: SDA hold, Start hold and Stop hold. Each of these is scaled by the multiplier. The block has no clock divider running outside a command. Every duration is counted in system-clock cycles from the moment a command is accepted.

A byte-level controller sits above this block and issues one command at a time over a valid/ready handshake. The commands are Start, Stop, write one data bit, and read one data bit. The block drives two open-drain enables; a 1 pulls the line low. When a command finishes, it raises a one-cycle completion pulse, which also carries the sampled bit for reads. A configuration write takes effect at once when the block is idle. If a command is in progress, the write is held back until that command ends.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is asserted and just after it, `sclOe` and `sdaOe` are 0, `cmdReady` is 1, `doneValid` is 0, `cfgErr` is 0, and the configuration byte is 0x00.
- R2: Configuration bits 7:6 select the multiplier m: 00 gives 1, 01 gives 2, 10 gives 4. Bits 5:0 form an index i that selects divider = 20 + 4*i, SDA hold = 1 + floor(i/2), Start hold = 4 + i and Stop hold = 5 + i.
- R3: `cmdKind` encodings are 00 Start, 01 Stop, 10 write `cmdBit`, 11 read. A write or read pulls SCL low at acceptance and releases it m*divider/2 cycles later. SCL stays released for the remaining m*divider - m*divider/2 cycles, then is pulled low again. `doneBit` is 0 after a write.
- R4: In every command, SDA takes its new value exactly m*(SDA hold) cycles after acceptance. For a write bit 1 that value is released, and for a write bit 0 it is pulled low. A read releases SDA. A Start releases SDA, and a Stop pulls it low. SDA never changes while SCL is released, except for the Start and Stop edges.
- R5: A Start leaves SCL unchanged for m*divider/2 cycles and then releases it. After a further m*divider - m*divider/2 cycles it pulls SDA low. It pulls SCL low exactly m*(Start hold) cycles after that.
- R6: A Stop pulls SCL low at acceptance and releases it m*divider/2 cycles later. It then releases SDA exactly m*(Stop hold) cycles after SCL was released.
- R7: A read samples `sdaIn` in the middle of the SCL-released phase and returns the sample on `doneBit` with the completion pulse.
- R8: `cmdReady` is 1 exactly when no command is in progress. `doneValid` is a single-cycle pulse. It appears in the cycle right after the edge that makes the last line change of the command, and `cmdReady` is 1 in that same cycle.
- R9: A configuration write while idle applies to the next command, including a command accepted in the same cycle. A write during a command leaves that command's timing unchanged and is applied when the command completes. If several writes arrive during one command, the last one is applied.
- R10: Multiplier code 11 is timed as multiplier 1 and sets `cfgErr`. `cfgErr` stays at 1 until reset, even after a legal code is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgWrData | input | 8 | Multiplier code (7:6) and table index (5:0) |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Block idle, command accepted when valid |
| cmdKind | input | 2 | Command code |
| cmdBit | input | 1 | Data bit for a write command |
| sdaIn | input | 1 | Sensed SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| doneValid | output | 1 | One-cycle completion pulse |
| doneBit | output | 1 | Read sample, 0 for other commands |
| cfgErr | output | 1 | Sticky reserved-multiplier flag |

## Verification
The bench records the exact edge of every enable change and compares it with times computed from the timing table. A design off by one in any counter compare therefore shows as a shifted SCL rise, shifted SDA edge or shifted completion. Configuration writes are issued in the same cycle as acceptance and during busy commands, one or two at a time. This exposes a design that changes timing mid-command, ignores the deferred value, or keeps the first of two writes instead of the last. The table corners (index 0 with multiplier 1, index 63 with multiplier 4) and the reserved code target a wrong shift amount, an overflowing counter, and a cleared or missing error flag. Edge counts per command catch glitches or SDA moves while SCL is released.

// File: rtl/i2c_bit_timer_pkg.sv
package i2c_bit_timer_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'b00,
    CMD_STOP  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_READ  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_HOLD = 2'd3
  } state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic idle;
    logic finish;
    logic sample;
  } strobe_t;

  // datapath -> control compare flags
  typedef struct packed {
    logic atHold;
    logic atLow;
    logic atHigh;
    logic atMid;
    logic atStart;
    logic atStop;
  } flags_t;

endpackage

// File: rtl/i2c_bit_timer_table.sv
module i2c_bit_timer_table #(
  parameter int IDX_W    = 6,
  parameter int VAL_W    = 9,
  parameter int DIV_BASE = 20,
  parameter int DIV_STEP = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic [VAL_W-1:0] divVal,
  output logic [VAL_W-1:0] sdaHoldVal,
  output logic [VAL_W-1:0] startHoldVal,
  output logic [VAL_W-1:0] stopHoldVal
);
  localparam int SDA_BASE   = 1;
  localparam int START_BASE = 4;
  localparam int STOP_BASE  = 5;

  // Rows are computed, not stored: divider grows by a fixed step, holds stay
  // below half the divider for every index.
  assign divVal       = VAL_W'(DIV_BASE) + VAL_W'(idx) * VAL_W'(DIV_STEP);
  assign sdaHoldVal   = VAL_W'(SDA_BASE) + VAL_W'(idx >> 1);
  assign startHoldVal = VAL_W'(START_BASE) + VAL_W'(idx);
  assign stopHoldVal  = VAL_W'(STOP_BASE) + VAL_W'(idx);

  always_comb begin
    assert (startHoldVal < (divVal >> 1) && stopHoldVal < (divVal >> 1))
      else $error("p_hold_below_half_r2: hold not below half divider");
  end
endmodule

// File: rtl/i2c_bit_timer_dp.sv
module i2c_bit_timer_dp
  import i2c_bit_timer_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int MULT_W   = 2,
  parameter int DIV_BASE = 20,
  parameter int DIV_STEP = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [MULT_W+IDX_W-1:0] cfgWrData,
  input  logic                    sdaIn,
  input  strobe_t                 strb,
  output flags_t                  flags,
  output logic                    sampledBit,
  output logic                    cfgErr
);
  localparam int CFG_W  = MULT_W + IDX_W;
  localparam int VAL_W  = $clog2(DIV_BASE + DIV_STEP * ((1 << IDX_W) - 1) + 1);
  localparam int MAX_SH = (1 << MULT_W) - 2;
  localparam int CNT_W  = VAL_W + MAX_SH;
  localparam int N_VAL  = 4;

  logic [CFG_W-1:0]  cfgReg, pendCfg, applyVal;
  logic              pendValid, applyEn;
  logic [CNT_W-1:0]  cnt;
  logic [MULT_W-1:0] multCode;
  logic [1:0]        shAmt;
  logic [VAL_W-1:0]  rawVal    [N_VAL];
  logic [CNT_W-1:0]  scaledVal [N_VAL];
  logic [CNT_W-1:0]  lowLen, highLen, midLen;

  // configuration apply / defer
  always_comb begin
    applyEn  = 1'b0;
    applyVal = cfgWrData;
    if (strb.idle && cfgWrEn) begin
      applyEn = 1'b1;
    end else if (strb.finish) begin
      if (cfgWrEn) begin
        applyEn = 1'b1;
      end else if (pendValid) begin
        applyEn  = 1'b1;
        applyVal = pendCfg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= '0;
      pendCfg   <= '0;
      pendValid <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      if (applyEn) cfgReg <= applyVal;
      if (applyEn && (applyVal[CFG_W-1 -: MULT_W] == {MULT_W{1'b1}})) cfgErr <= 1'b1;
      if (strb.finish) begin
        pendValid <= 1'b0;
      end else if (cfgWrEn && !strb.idle) begin
        pendValid <= 1'b1;
        pendCfg   <= cfgWrData;
      end
    end
  end

  // multiplier code -> shift; reserved code behaves as x1
  assign multCode = cfgReg[CFG_W-1 -: MULT_W];
  always_comb begin
    if (multCode == {MULT_W{1'b1}}) shAmt = 2'd0;
    else                            shAmt = 2'(multCode);
  end

  i2c_bit_timer_table #(
    .IDX_W(IDX_W), .VAL_W(VAL_W), .DIV_BASE(DIV_BASE), .DIV_STEP(DIV_STEP)
  ) u_table (
    .idx          (cfgReg[IDX_W-1:0]),
    .divVal       (rawVal[0]),
    .sdaHoldVal   (rawVal[1]),
    .startHoldVal (rawVal[2]),
    .stopHoldVal  (rawVal[3])
  );

  for (genvar g = 0; g < N_VAL; g++) begin : g_scale
    assign scaledVal[g] = CNT_W'(rawVal[g]) << shAmt;
  end

  assign lowLen  = scaledVal[0] >> 1;
  assign highLen = scaledVal[0] - lowLen;
  assign midLen  = highLen >> 1;

  // phase counter
  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else                  cnt <= cnt + CNT_W'(1);
  end

  assign flags.atHold  = (cnt == scaledVal[1] - CNT_W'(1));
  assign flags.atLow   = (cnt == lowLen - CNT_W'(1));
  assign flags.atHigh  = (cnt == highLen - CNT_W'(1));
  assign flags.atMid   = (cnt == midLen - CNT_W'(1));
  assign flags.atStart = (cnt == scaledVal[2] - CNT_W'(1));
  assign flags.atStop  = (cnt == scaledVal[3] - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)            sampledBit <= 1'b0;
    else if (strb.sample) sampledBit <= sdaIn;
  end

  p_cfg_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.idle && !strb.finish) |=> $stable(cfgReg));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
  p_reserved_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    (multCode == {MULT_W{1'b1}}) |-> cfgErr);
endmodule

// File: rtl/i2c_bit_timer_ctl.sv
module i2c_bit_timer_ctl
  import i2c_bit_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  input  logic       cmdBit,
  input  flags_t     flags,
  input  logic       sampledBit,
  output logic       cmdReady,
  output strobe_t    strb,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       doneValid,
  output logic       doneBit
);
  state_e state;
  cmd_e   kindReg;
  logic   bitReg;

  assign cmdReady = (state == ST_IDLE);

  always_comb begin
    strb      = '0;
    strb.idle = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: strb.cntClr = 1'b1;
      ST_LOW:  strb.cntClr = flags.atLow;
      ST_HIGH: begin
        strb.sample = flags.atMid && (kindReg == CMD_READ);
        strb.cntClr = flags.atHigh && (kindReg == CMD_START);
        strb.finish = flags.atHigh && (kindReg != CMD_START);
      end
      ST_HOLD: strb.finish = (kindReg == CMD_START) ? flags.atStart : flags.atStop;
      default: strb.cntClr = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kindReg   <= CMD_START;
      bitReg    <= 1'b0;
      sclOe     <= 1'b0;
      sdaOe     <= 1'b0;
      doneValid <= 1'b0;
      doneBit   <= 1'b0;
    end else begin
      doneValid <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmdValid) begin
          kindReg <= cmd_e'(cmdKind);
          bitReg  <= cmdBit;
          state   <= ST_LOW;
          if (cmd_e'(cmdKind) != CMD_START) sclOe <= 1'b1;
        end
        ST_LOW: begin
          if (flags.atHold) begin
            unique case (kindReg)
              CMD_STOP:  sdaOe <= 1'b1;
              CMD_WRITE: sdaOe <= !bitReg;
              default:   sdaOe <= 1'b0;
            endcase
          end
          if (flags.atLow) begin
            sclOe <= 1'b0;
            state <= (kindReg == CMD_STOP) ? ST_HOLD : ST_HIGH;
          end
        end
        ST_HIGH: if (flags.atHigh) begin
          if (kindReg == CMD_START) begin
            sdaOe <= 1'b1;
            state <= ST_HOLD;
          end else begin
            sclOe <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_HOLD: if (strb.finish) begin
          if (kindReg == CMD_START) sclOe <= 1'b1;
          else                      sdaOe <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (strb.finish) begin
        doneValid <= 1'b1;
        doneBit   <= (kindReg == CMD_READ) ? sampledBit : 1'b0;
      end
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_done_when_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> cmdReady);
  p_scl_low_phase_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW && kindReg != CMD_START) |-> sclOe);
  p_sda_while_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(sclOe)) |-> (kindReg == CMD_START || kindReg == CMD_STOP));
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bit_timer_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int MULT_W   = 2,
  parameter int DIV_BASE = 20,
  parameter int DIV_STEP = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [MULT_W+IDX_W-1:0] cfgWrData,
  input  logic                    cmdValid,
  output logic                    cmdReady,
  input  logic [1:0]              cmdKind,
  input  logic                    cmdBit,
  input  logic                    sdaIn,
  output logic                    sclOe,
  output logic                    sdaOe,
  output logic                    doneValid,
  output logic                    doneBit,
  output logic                    cfgErr
);
  strobe_t strb;
  flags_t  flags;
  logic    sampledBit;

  i2c_bit_timer_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdKind    (cmdKind),
    .cmdBit     (cmdBit),
    .flags      (flags),
    .sampledBit (sampledBit),
    .cmdReady   (cmdReady),
    .strb       (strb),
    .sclOe      (sclOe),
    .sdaOe      (sdaOe),
    .doneValid  (doneValid),
    .doneBit    (doneBit)
  );

  i2c_bit_timer_dp #(
    .IDX_W(IDX_W), .MULT_W(MULT_W), .DIV_BASE(DIV_BASE), .DIV_STEP(DIV_STEP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .sdaIn      (sdaIn),
    .strb       (strb),
    .flags      (flags),
    .sampledBit (sampledBit),
    .cfgErr     (cfgErr)
  );
endmodule

// File: tb/i2c_bit_timer_bench.sv
module i2c_bit_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_START = 2'b00, K_STOP = 2'b01, K_WRITE = 2'b10, K_READ = 2'b11;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0, cmdValid = 1'b0, cmdBit = 1'b0, slaveBit = 1'b1;
  logic [7:0] cfgWrData = '0;
  logic [1:0] cmdKind = '0;
  logic cmdReady, sclOe, sdaOe, doneValid, doneBit, cfgErr, sdaIn;

  assign sdaIn = sdaOe ? 1'b0 : slaveBit;

  i2c_bit_timer u_i2c_bit_timer (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind), .cmdBit(cmdBit),
    .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .doneValid(doneValid),
    .doneBit(doneBit), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFail = 0;

  // edge recorder
  logic prevScl = 1'b0, prevSda = 1'b0;
  int sclFallE, sclRiseE, sdaPullE, sdaRelE, sclCnt, sdaCnt;
  always @(negedge clk) begin
    if (sclOe !== prevScl) begin
      sclCnt++;
      if (sclOe) sclFallE = cyc; else sclRiseE = cyc;
    end
    if (sdaOe !== prevSda) begin
      sdaCnt++;
      if (sdaOe) sdaPullE = cyc; else sdaRelE = cyc;
    end
    prevScl = sclOe;
    prevSda = sdaOe;
  end

  // bench model state
  logic [7:0] curCfg = '0;
  logic mScl = 1'b0, mSda = 1'b0, mErr = 1'b0;

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int multOf(input logic [7:0] c);
    return (c[7:6] == 2'b01) ? 2 : (c[7:6] == 2'b10) ? 4 : 1;
  endfunction
  function automatic int divOf(input logic [7:0] c);
    return multOf(c) * (20 + 4 * int'(c[5:0]));
  endfunction
  function automatic int lowOf(input logic [7:0] c);
    return divOf(c) / 2;
  endfunction
  function automatic int highOf(input logic [7:0] c);
    return divOf(c) - lowOf(c);
  endfunction
  function automatic int hsOf(input logic [7:0] c);
    return multOf(c) * (1 + int'(c[5:0]) / 2);
  endfunction
  function automatic int stOf(input logic [7:0] c);
    return multOf(c) * (4 + int'(c[5:0]));
  endfunction
  function automatic int spOf(input logic [7:0] c);
    return multOf(c) * (5 + int'(c[5:0]));
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    curCfg = d;
    if (d[7:6] == 2'b11) mErr = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    chkEq("R10", "cfgErr after write", int'(cfgErr), int'(mErr));
  endtask

  // wrMode: 0 none, 1 idle write in the accept cycle, 2 one busy write, 3 two busy writes
  task automatic runCmd(input logic [1:0] kind, input logic b, input int wrMode,
                        input logic [7:0] w1, input logic [7:0] w2);
    int acc, doneE, k, L, H, hs, st, sp;
    logic pScl, pSda, newSda;
    logic [7:0] c;
    @(negedge clk);
    chkEq("R8", "ready when idle", int'(cmdReady), 1);
    if (wrMode == 1) begin
      cfgWrEn = 1'b1; cfgWrData = w1; curCfg = w1;
      if (w1[7:6] == 2'b11) mErr = 1'b1;
    end
    c = curCfg;
    L = lowOf(c); H = highOf(c); hs = hsOf(c); st = stOf(c); sp = spOf(c);
    pScl = mScl; pSda = mSda;
    sclFallE = -1; sclRiseE = -1; sdaPullE = -1; sdaRelE = -1; sclCnt = 0; sdaCnt = 0;
    acc = cyc + 1;
    cmdValid = 1'b1; cmdKind = kind; cmdBit = b;
    @(negedge clk);
    cmdValid = 1'b0; cfgWrEn = 1'b0;
    chkEq("R8", "ready low while busy", int'(cmdReady), 0);
    k = 0;
    while (!doneValid && k < 20000) begin
      if (wrMode >= 2 && k == 2) begin cfgWrEn = 1'b1; cfgWrData = w1; end
      else if (wrMode == 3 && k == 4) begin cfgWrEn = 1'b1; cfgWrData = w2; end
      else cfgWrEn = 1'b0;
      @(negedge clk);
      k++;
    end
    cfgWrEn = 1'b0;
    if (!doneValid) chkEq("R8", "completion seen", 0, 1);
    doneE = cyc;
    #1;
    chkEq("R8", "ready with done", int'(cmdReady), 1);
    case (kind)
      K_WRITE, K_READ: begin
        newSda = (kind == K_WRITE) ? !b : 1'b0;
        chkEq("R3", "bit scl release", sclRiseE, acc + L);
        chkEq("R3", "bit scl pull", sclFallE, acc + L + H);
        chkEq("R3", "bit scl edges", sclCnt, pScl ? 2 : 3);
        chkEq("R8", "bit done edge", doneE, acc + L + H);
        if (newSda != pSda)
          chkEq("R4", "bit sda hold", newSda ? sdaPullE : sdaRelE, acc + hs);
        chkEq("R4", "bit sda edges", sdaCnt, (newSda != pSda) ? 1 : 0);
        if (kind == K_READ) chkEq("R7", "read sample", int'(doneBit), int'(slaveBit));
        else                chkEq("R3", "write doneBit", int'(doneBit), 0);
        mScl = 1'b1; mSda = newSda;
      end
      K_START: begin
        if (pScl) chkEq("R5", "start scl release", sclRiseE, acc + L);
        if (pSda) chkEq("R4", "start sda release hold", sdaRelE, acc + hs);
        chkEq("R5", "start sda fall", sdaPullE, acc + L + H);
        chkEq("R5", "start hold", sclFallE - sdaPullE, st);
        chkEq("R5", "start scl edges", sclCnt, pScl ? 2 : 1);
        chkEq("R5", "start sda edges", sdaCnt, pSda ? 2 : 1);
        chkEq("R8", "start done edge", doneE, acc + L + H + st);
        mScl = 1'b1; mSda = 1'b1;
      end
      default: begin
        if (!pScl) chkEq("R6", "stop scl pull", sclFallE, acc);
        if (!pSda) chkEq("R4", "stop sda pull hold", sdaPullE, acc + hs);
        chkEq("R6", "stop scl release", sclRiseE, acc + L);
        chkEq("R6", "stop hold", sdaRelE - sclRiseE, sp);
        chkEq("R6", "stop scl edges", sclCnt, pScl ? 1 : 2);
        chkEq("R6", "stop sda edges", sdaCnt, pSda ? 1 : 2);
        chkEq("R8", "stop done edge", doneE, acc + L + sp);
        mScl = 1'b0; mSda = 1'b0;
      end
    endcase
    if (wrMode >= 2) begin
      curCfg = (wrMode == 3) ? w2 : w1;
      if (w1[7:6] == 2'b11 || (wrMode == 3 && w2[7:6] == 2'b11)) mErr = 1'b1;
    end
    @(negedge clk);
    chkEq("R8", "done single cycle", int'(doneValid), 0);
    chkEq("R10", "cfgErr", int'(cfgErr), int'(mErr));
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles max", cyc, 190000);
    finishRun();
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chkEq("R1", "sclOe in reset", int'(sclOe), 0);
    chkEq("R1", "sdaOe in reset", int'(sdaOe), 0);
    chkEq("R1", "ready in reset", int'(cmdReady), 1);
    chkEq("R1", "done in reset", int'(doneValid), 0);
    chkEq("R1", "cfgErr in reset", int'(cfgErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "sclOe after reset", int'(sclOe), 0);
    chkEq("R1", "sdaOe after reset", int'(sdaOe), 0);

    // R2: reset configuration (x1, index 0)
    runCmd(K_START, 1'b0, 0, 8'h00, 8'h00);
    runCmd(K_WRITE, 1'b1, 0, 8'h00, 8'h00);
    runCmd(K_WRITE, 1'b0, 0, 8'h00, 8'h00);
    slaveBit = 1'b1; runCmd(K_READ, 1'b0, 0, 8'h00, 8'h00);
    slaveBit = 1'b0; runCmd(K_READ, 1'b0, 0, 8'h00, 8'h00);
    runCmd(K_STOP, 1'b0, 0, 8'h00, 8'h00);

    // R2 multiplier x2 via idle write, R9 write in the accept cycle
    cfgWrite(8'h4A);
    runCmd(K_START, 1'b0, 0, 8'h00, 8'h00);
    runCmd(K_WRITE, 1'b0, 1, 8'h83, 8'h00);
    // R9 deferred writes: single and last-of-two
    runCmd(K_WRITE, 1'b1, 2, 8'h05, 8'h00);
    runCmd(K_WRITE, 1'b0, 0, 8'h00, 8'h00);
    runCmd(K_READ, 1'b0, 3, 8'h41, 8'h92);
    runCmd(K_STOP, 1'b0, 0, 8'h00, 8'h00);

    // R10 reserved code timed as x1, sticky flag
    cfgWrite(8'hC7);
    runCmd(K_START, 1'b0, 0, 8'h00, 8'h00);
    runCmd(K_WRITE, 1'b1, 0, 8'h00, 8'h00);
    cfgWrite(8'h07);
    runCmd(K_STOP, 1'b0, 0, 8'h00, 8'h00);

    // R2 table corner: largest index, x4
    cfgWrite(8'hBF);
    runCmd(K_START, 1'b0, 0, 8'h00, 8'h00);
    runCmd(K_WRITE, 1'b0, 0, 8'h00, 8'h00);
    runCmd(K_STOP, 1'b0, 0, 8'h00, 8'h00);

    // random mix
    for (int n = 0; n < 150; n++) begin
      logic [7:0] rc, rw1, rw2;
      int mode;
      rc  = {2'($urandom_range(0, 3)), 2'b00, 4'($urandom_range(0, 15))};
      rw1 = {2'($urandom_range(0, 3)), 2'b00, 4'($urandom_range(0, 15))};
      rw2 = {2'($urandom_range(0, 3)), 2'b00, 4'($urandom_range(0, 15))};
      if ($urandom_range(0, 4) == 0) cfgWrite(rc);
      mode = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0;
      slaveBit = 1'($urandom_range(0, 1));
      runCmd(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), mode, rw1, rw2);
    end

    finishRun();
  end
endmodule